// File: doc/BRIEF.md
# Indirect Shared Register Access Bridge

This block lets a host register bus reach a bank of internal shared registers that are not mapped into the host address space. The host sees two words: a control word and a data word. The control word holds a 16-bit target offset and a 2-bit command, and reports busy and error status. A read command fetches the addressed shared register into the data word. A write command sends the data word, loaded beforehand, to the addressed shared register.

On the inside the bridge drives a request/acknowledge port. The request and its address, direction and write data stay stable until the target acknowledges for one cycle. The bridge has no power-ready or core-ready input, so it works whenever its own clock and reset are running. While a transaction is outstanding, further host writes to either word are refused and flagged.

Top module: `ixb_bridge`

## Requirements
- R1: After reset the control word and the data word both read as zero and `sh_req` is low.
- R2: A host write to offset 0x0EC whose bits [29:28] equal 2 starts a read. In the next cycle `sh_req` is high, `sh_we` is low and `sh_addr` equals bits [15:0] of that write.
- R3: A host write to offset 0x0EC whose bits [29:28] equal 3 starts a write. In the next cycle `sh_req` and `sh_we` are high and `sh_wdata` equals the data word, which is written at offset 0x0F4. Address, direction and write data stay stable until the acknowledge.
- R4: Control bit 31 (busy) reads as 1 from the cycle after a read or write command until the edge where `sh_ack` is sampled high. `sh_req` stays high until that edge and is low after it.
- R5: On a read, the value on `sh_rdata` at the acknowledging edge becomes the data word.
- R6: A control write with bits [29:28] equal to 0 or 1 stores its offset and command but starts no access. `sh_req` stays low and busy stays 0.
- R7: While busy, a host write to either word is ignored and sets control bit 30 (error). The error bit stays set.
- R8: An accepted control write (not busy) with bit 30 set clears the error bit.
- R9: A host read returns its data one cycle after the read strobe. The control word reads as {busy, error, command[1:0], twelve zeros, offset[15:0]}. Other offsets read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host write strobe |
| host_rd_en | input | 1 | Host read strobe |
| host_addr | input | 12 | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, registered |
| sh_req | output | 1 | Shared port request, held until acknowledge |
| sh_we | output | 1 | Shared port direction, 1 = write |
| sh_addr | output | 16 | Shared register offset |
| sh_wdata | output | 32 | Shared port write data |
| sh_ack | input | 1 | Shared port acknowledge, one-cycle pulse |
| sh_rdata | input | 32 | Shared port read data, valid with acknowledge |

## Verification
A command accepted at a clock edge shows on the shared port by the following falling edge. The bench checks request, direction, address and write data exactly there. Busy and a read's data are due at the acknowledging edge, and host readback adds one registered cycle, so the bench samples each host read at the falling edge after the read strobe is taken. Acknowledge latency is held at zero and at six cycles for the directed collision cases, so a refused write lands exactly in the busy window. The random phase draws 0 to 3 cycles and waits for `sh_req` to fall before it compares.

// File: rtl/ixb_pkg.sv
package ixb_pkg;
  typedef enum logic [1:0] {
    IXB_IDLE0 = 2'd0,
    IXB_IDLE1 = 2'd1,
    IXB_READ  = 2'd2,
    IXB_WRITE = 2'd3
  } ixb_cmd_e;

  localparam int IXB_OFS_W    = 16;
  localparam int IXB_CMD_LSB  = 28;
  localparam int IXB_ERR_BIT  = 30;
  localparam int IXB_BUSY_BIT = 31;
endpackage

// File: rtl/ixb_host_decode.sv
module ixb_host_decode #(
  parameter int AW       = 12,
  parameter int DW       = 32,
  parameter logic [AW-1:0] CTRL_OFS = 12'h0EC,
  parameter logic [AW-1:0] DATA_OFS = 12'h0F4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] ctrl_word,
  input  logic [DW-1:0] data_word,
  output logic          ctrl_wr,
  output logic          data_wr,
  output logic [DW-1:0] rdata
);
  logic hit_ctrl, hit_data;

  always_comb begin
    hit_ctrl = (addr == CTRL_OFS);
    hit_data = (addr == DATA_OFS);
    ctrl_wr  = wr_en && hit_ctrl;
    data_wr  = wr_en && hit_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      if (hit_ctrl)      rdata <= ctrl_word;
      else if (hit_data) rdata <= data_word;
      else               rdata <= '0;
    end
  end

  // R9: a read of an unmapped offset returns zero
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !hit_ctrl && !hit_data) |=> (rdata == '0));
endmodule

// File: rtl/ixb_engine.sv
module ixb_engine
  import ixb_pkg::*;
#(
  parameter int DW    = 32,
  parameter int OFS_W = IXB_OFS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_wr,
  input  logic             data_wr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    ctrl_word,
  output logic [DW-1:0]    data_word,
  output logic             req,
  output logic             req_we,
  output logic [OFS_W-1:0] req_addr,
  output logic [DW-1:0]    req_wdata,
  input  logic             ack,
  input  logic [DW-1:0]    ack_rdata
);
  localparam int PAD_W = IXB_CMD_LSB - OFS_W;

  logic             pend;
  logic             err;
  ixb_cmd_e         cmd;
  logic [OFS_W-1:0] ofs;
  logic [DW-1:0]    data_q;
  logic             accept;
  logic             start;
  logic             refuse;

  always_comb begin
    accept = ctrl_wr && !pend;
    start  = accept && wdata[IXB_CMD_LSB+1];
    refuse = (ctrl_wr || data_wr) && pend;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend   <= 1'b0;
      err    <= 1'b0;
      cmd    <= IXB_IDLE0;
      ofs    <= '0;
      data_q <= '0;
    end else begin
      if (refuse)
        err <= 1'b1;
      else if (accept && wdata[IXB_ERR_BIT])
        err <= 1'b0;

      if (accept) begin
        ofs <= wdata[OFS_W-1:0];
        cmd <= ixb_cmd_e'(wdata[IXB_CMD_LSB +: 2]);
      end

      if (data_wr && !pend)
        data_q <= wdata;

      if (start) begin
        pend <= 1'b1;
      end else if (pend && ack) begin
        pend <= 1'b0;
        if (cmd == IXB_READ)
          data_q <= ack_rdata;
      end
    end
  end

  always_comb begin
    ctrl_word = {pend, err, cmd, {PAD_W{1'b0}}, ofs};
    data_word = data_q;
    req       = pend;
    req_we    = (cmd == IXB_WRITE);
    req_addr  = ofs;
    req_wdata = data_q;
  end

  // R4: the request is held until the target acknowledges
  a_r4_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
    (req && !ack) |=> req);
  // R4: an acknowledge ends the request
  a_r4_release_on_ack: assert property (@(posedge clk) disable iff (rst)
    (req && ack) |=> !req);
  // R3: request attributes are stable while outstanding
  a_r3_stable_request: assert property (@(posedge clk) disable iff (rst)
    (req && !ack) |=> ($stable(req_addr) && $stable(req_we) && $stable(req_wdata)));
  // R6: a no-access command never raises the request
  a_r6_nop_no_request: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !req && !wdata[IXB_CMD_LSB+1]) |=> !req);
  // R7: the error bit only rises after a write during busy
  a_r7_err_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(ctrl_word[IXB_ERR_BIT]) |-> $past(req && (ctrl_wr || data_wr)));
endmodule

// File: rtl/ixb_bridge.sv
module ixb_bridge
  import ixb_pkg::*;
#(
  parameter int AW    = 12,
  parameter int DW    = 32,
  parameter int OFS_W = IXB_OFS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_wr_en,
  input  logic             host_rd_en,
  input  logic [AW-1:0]    host_addr,
  input  logic [DW-1:0]    host_wdata,
  output logic [DW-1:0]    host_rdata,
  output logic             sh_req,
  output logic             sh_we,
  output logic [OFS_W-1:0] sh_addr,
  output logic [DW-1:0]    sh_wdata,
  input  logic             sh_ack,
  input  logic [DW-1:0]    sh_rdata
);
  logic          ctrl_wr, data_wr;
  logic [DW-1:0] ctrl_word, data_word;

  ixb_host_decode #(.AW(AW), .DW(DW)) u_decode (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (host_wr_en),
    .rd_en     (host_rd_en),
    .addr      (host_addr),
    .ctrl_word (ctrl_word),
    .data_word (data_word),
    .ctrl_wr   (ctrl_wr),
    .data_wr   (data_wr),
    .rdata     (host_rdata)
  );

  ixb_engine #(.DW(DW), .OFS_W(OFS_W)) u_engine (
    .clk       (clk),
    .rst       (rst),
    .ctrl_wr   (ctrl_wr),
    .data_wr   (data_wr),
    .wdata     (host_wdata),
    .ctrl_word (ctrl_word),
    .data_word (data_word),
    .req       (sh_req),
    .req_we    (sh_we),
    .req_addr  (sh_addr),
    .req_wdata (sh_wdata),
    .ack       (sh_ack),
    .ack_rdata (sh_rdata)
  );
endmodule

// File: tb/test_ixb_bridge.sv
`timescale 1ns/1ps
module test_ixb_bridge;
  localparam logic [11:0] A_CTRL = 12'h0EC;
  localparam logic [11:0] A_DATA = 12'h0F4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr_en = 1'b0;
  logic        host_rd_en = 1'b0;
  logic [11:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        sh_req, sh_we;
  logic [15:0] sh_addr;
  logic [31:0] sh_wdata;
  logic        sh_ack = 1'b0;
  logic [31:0] sh_rdata = '0;

  int n_chk = 0;
  int n_bad = 0;
  int lat_cfg = 0;
  bit done = 1'b0;

  logic [31:0] tgt_mem [16];
  logic [31:0] exp_mem [16];
  logic        exp_err;
  logic [1:0]  exp_cmd;
  logic [15:0] exp_ofs;
  logic [31:0] exp_data;

  always #4 clk = ~clk;

  ixb_bridge i_ixb_bridge (
    .clk(clk), .rst(rst),
    .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .sh_req(sh_req), .sh_we(sh_we), .sh_addr(sh_addr), .sh_wdata(sh_wdata),
    .sh_ack(sh_ack), .sh_rdata(sh_rdata)
  );

  function automatic logic [31:0] ctrl_exp(input logic busy);
    return {busy, exp_err, exp_cmd, 12'h000, exp_ofs};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [11:0] a, input logic [31:0] d);
    host_wr_en = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk); @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic hread(input logic [11:0] a, output logic [31:0] d);
    host_rd_en = 1'b1; host_addr = a;
    @(posedge clk); @(negedge clk);
    host_rd_en = 1'b0;
    d = host_rdata;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 40 && sh_req; i++) @(negedge clk);
    check("R4 request ends", {31'd0, sh_req}, 32'd0);
  endtask

  // bench model: apply a control write that is accepted (idle)
  task automatic model_ctrl(input logic [31:0] w);
    if (w[30]) exp_err = 1'b0;
    exp_ofs = w[15:0];
    exp_cmd = w[29:28];
  endtask

  // target register file with configurable acknowledge latency
  initial begin
    bit active = 1'b0;
    int cnt = 0;
    for (int i = 0; i < 16; i++) tgt_mem[i] = '0;
    forever begin
      @(negedge clk);
      if (sh_ack) begin
        sh_ack = 1'b0;
      end else if (sh_req) begin
        if (!active) begin
          active = 1'b1;
          cnt = (lat_cfg >= 0) ? lat_cfg : int'($urandom_range(0, 3));
        end
        if (cnt == 0) begin
          if (sh_we) tgt_mem[sh_addr[3:0]] = sh_wdata;
          else       sh_rdata = tgt_mem[sh_addr[3:0]];
          sh_ack = 1'b1;
          active = 1'b0;
        end else begin
          cnt--;
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] w;
    void'($urandom(32'h1A2B3C4D));
    for (int i = 0; i < 16; i++) exp_mem[i] = '0;
    exp_err = 0; exp_cmd = 0; exp_ofs = 0; exp_data = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 req", {31'd0, sh_req}, 32'd0);
    hread(A_CTRL, rd); check("R1 ctrl", rd, 32'd0);
    hread(A_DATA, rd); check("R1 data", rd, 32'd0);

    // R9 unmapped offsets
    hwrite(A_DATA, 32'hA5A5_0F0F); exp_data = 32'hA5A5_0F0F;
    hwrite(12'h0F0, 32'hFFFF_FFFF);
    hread(12'h0F0, rd); check("R9 unmapped read", rd, 32'd0);
    hread(A_DATA, rd); check("R9 unmapped write no effect", rd, exp_data);

    // R6 no-access commands
    w = 32'hFFF1_1234 & ~32'h2000_0000; // cmd=1, junk in bits 27:16 and 31:30
    w[30] = 1'b0;
    hwrite(A_CTRL, w); model_ctrl(w);
    check("R6 no request cmd1", {31'd0, sh_req}, 32'd0);
    hread(A_CTRL, rd); check("R6 R9 ctrl after cmd1", rd, ctrl_exp(1'b0));
    w = 32'h0000_0ABC;
    hwrite(A_CTRL, w); model_ctrl(w);
    check("R6 no request cmd0", {31'd0, sh_req}, 32'd0);

    // R3 write with latency 0, R7 collision in the busy cycle
    lat_cfg = 0;
    hwrite(A_DATA, 32'hDEAD_0001); exp_data = 32'hDEAD_0001;
    w = 32'h3000_0005;
    hwrite(A_CTRL, w); model_ctrl(w);
    check("R3 req", {31'd0, sh_req}, 32'd1);
    check("R3 we", {31'd0, sh_we}, 32'd1);
    check("R3 addr", {16'd0, sh_addr}, 32'd5);
    check("R3 wdata", sh_wdata, exp_data);
    hwrite(A_CTRL, 32'h2000_0009); exp_err = 1'b1;
    exp_mem[5] = exp_data;
    wait_idle();
    hread(A_CTRL, rd); check("R7 ctrl write ignored, error set", rd, ctrl_exp(1'b0));

    // R8 clear error
    w = 32'h4000_0007;
    hwrite(A_CTRL, w); model_ctrl(w);
    hread(A_CTRL, rd); check("R8 error cleared", rd, ctrl_exp(1'b0));

    // R2 R4 R5 read with long latency; R7 data write refused
    lat_cfg = 6;
    w = 32'h2000_0005;
    hwrite(A_CTRL, w); model_ctrl(w);
    check("R2 req", {31'd0, sh_req}, 32'd1);
    check("R2 we", {31'd0, sh_we}, 32'd0);
    check("R2 addr", {16'd0, sh_addr}, 32'd5);
    hread(A_CTRL, rd); check("R4 busy visible", rd, ctrl_exp(1'b1));
    hwrite(A_DATA, 32'h0BAD_0BAD); exp_err = 1'b1;
    check("R4 req held", {31'd0, sh_req}, 32'd1);
    wait_idle();
    exp_data = exp_mem[5];
    hread(A_DATA, rd); check("R5 R7 data from target", rd, exp_data);
    hread(A_CTRL, rd); check("R7 error sticky", rd, ctrl_exp(1'b0));

    // random phase
    lat_cfg = -1;
    for (int it = 0; it < 400; it++) begin
      int op = int'($urandom_range(0, 3));
      if (op == 0) begin
        w = $urandom(); hwrite(A_DATA, w); exp_data = w;
      end else begin
        w = $urandom();
        w[19:16] = 4'h0;
        hwrite(A_CTRL, w); model_ctrl(w);
        if (w[29]) begin
          check("R2 R3 random req", {31'd0, sh_req}, 32'd1);
          check("R2 R3 random addr", {16'd0, sh_addr}, {16'd0, w[15:0]});
          check("R2 R3 random we", {31'd0, sh_we}, {31'd0, w[28]});
          if (w[28]) begin
            check("R3 random wdata", sh_wdata, exp_data);
            exp_mem[w[3:0]] = exp_data;
          end else begin
            exp_data = exp_mem[w[3:0]];
          end
          wait_idle();
        end else begin
          check("R6 random no req", {31'd0, sh_req}, 32'd0);
        end
        hread(A_CTRL, rd); check("R9 random ctrl", rd, ctrl_exp(1'b0));
        hread(A_DATA, rd); check("R5 random data", rd, exp_data);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule